// File: doc/BRIEF.md
# Page-Mode Burst Reader for Pseudo-SRAM

This block sits on the host side of an asynchronous pseudo-SRAM and turns one request into a short run of reads that all fall inside a single aligned page of sixteen words. The host supplies a start address, a word count and a flag that says whether the memory's configuration currently permits page reads. The engine drives chip enable, output enable and the address, samples the returned data at the right moment, and hands each word back with a valid strobe, its offset within the page, and a marker on the final word.

With page reads allowed, chip enable and output enable stay low for the whole run. The upper address bits never move and only the page offset steps. The first word waits the long random-access window and every later word waits the short in-page window. With page reads not allowed, each word becomes its own random read, and chip enable is released between words. A request that would run past the end of its page is cut at the page edge and flagged. Every burst ends with chip enable high. Access windows are given in clock cycles by parameters.

Top module: `page_burst_rd`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), and busy, read valid and the truncation flag are low.
- R2: A start pulse is taken only while busy is low; a start pulse during a burst produces no extra words and leaves the running burst unchanged.
- R3: The first word of a burst is sampled after the address and chip enable have been held for T_FIRST_CYC cycles, and read valid is a one-cycle strobe that rises T_FIRST_CYC cycles after the start edge.
- R4: With the page flag set to 1, chip enable stays low for the whole burst, address bits above the 4-bit page offset do not change, the offset rises by one per word, and each later word is delivered T_PAGE_CYC cycles after the one before it.
- R5: With the page flag set to 0, chip enable goes high for T_GAP_CYC cycles between words, the address does not change while chip enable is low, and every word waits the full T_FIRST_CYC cycles.
- R6: The number of words read is the smaller of the requested count and 16 minus the start offset; when the request is cut, the truncation flag pulses for one cycle, one cycle after the start edge.
- R7: A start pulse with a word count of 0 is ignored: busy stays low, chip enable stays high and no flag is raised.
- R8: Each delivered word carries its 4-bit page offset, equal to the address low bits it was read from, and the last-word marker is high on the final word of the burst only.
- R9: Chip enable is high whenever busy is low, and chip enable never stays low for CE_MAX_CYC cycles or more.
- R10: Output enable is low exactly when chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a burst (taken when busy is low) |
| start_addr_i | input | ADDR_W | First word address |
| word_cnt_i | input | OFF_W+1 | Words requested, 1 to 16 |
| page_en_i | input | 1 | Page reads allowed by configuration |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_rdata_i | input | DATA_W | Memory read data |
| rd_valid_o | output | 1 | Word strobe |
| rd_data_o | output | DATA_W | Word read |
| rd_off_o | output | OFF_W | Page offset of the word |
| rd_last_o | output | 1 | Final word of the burst |
| busy_o | output | 1 | Burst in progress |
| trunc_err_o | output | 1 | Request was cut at the page edge |

## Verification
The bench builds the block with a 22-bit address, 16-bit data, a 16-word page, a 7-cycle first access, a 2-cycle page access, a 1-cycle chip-enable gap and a 1000-cycle chip-enable limit. With these windows a full page burst finishes in 37 cycles, so starts at every offset, starts at the top of the address space, truncation down to one word, and both the page and random orderings are covered. The memory model in the bench returns garbage until the proper window has passed since the last address or chip-enable change. Any sampling that comes too early therefore shows up as a data mismatch.

// File: rtl/page_burst_rd_pkg.sv
package page_burst_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } pbr_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pbr_req_clip.sv
module pbr_req_clip #(
  parameter int unsigned OFF_W = 4,
  localparam int unsigned CNT_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] len_o,
  output logic             err_o,
  output logic             zero_o
);
  localparam int unsigned PAGE_WORDS = 2 ** OFF_W;

  logic [CNT_W-1:0] room;

  always_comb begin
    room   = CNT_W'(PAGE_WORDS) - {1'b0, off_i};
    err_o  = cnt_i > room;
    len_o  = err_o ? room : cnt_i;
    zero_o = cnt_i == '0;
  end

endmodule

// File: rtl/pbr_wait_timer.sv
module pbr_wait_timer #(
  parameter int unsigned TMR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             done_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = cnt_q == '0;

  // R3: an expired window stays expired until reloaded
  a_r3_tmr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/pbr_seq.sv
module pbr_seq
  import page_burst_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned OFF_W       = 4,
  parameter int unsigned T_FIRST_CYC = 7,
  parameter int unsigned T_PAGE_CYC  = 2,
  parameter int unsigned T_GAP_CYC   = 1,
  parameter int unsigned CE_MAX_CYC  = 1000,
  parameter int unsigned TMR_W       = 3,
  localparam int unsigned CNT_W  = OFF_W + 1,
  localparam int unsigned HI_W   = ADDR_W - OFF_W,
  localparam int unsigned CEC_W  = $clog2(CE_MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              err_i,
  input  logic              zero_i,
  input  logic              page_en_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic [TMR_W-1:0]  tmr_val_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic              rd_last_o,
  output logic              busy_o,
  output logic              trunc_err_o
);
  pbr_state_e        state_q;
  logic [HI_W-1:0]   hi_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  left_q;
  logic              page_q;
  logic [CEC_W-1:0]  ce_low_q;
  logic              take;
  logic              last_word;

  assign take      = (state_q == ST_IDLE) && start_i && !zero_i;
  assign last_word = left_q == CNT_W'(1);

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (take) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(T_FIRST_CYC - 1);
      end
      ST_ACCESS: if (tmr_done_i && !last_word) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = page_q ? TMR_W'(T_PAGE_CYC - 1) : TMR_W'(T_GAP_CYC - 1);
      end
      ST_GAP: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(T_FIRST_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      hi_q        <= '0;
      off_q       <= '0;
      left_q      <= '0;
      page_q      <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      rd_off_o    <= '0;
      rd_last_o   <= 1'b0;
      trunc_err_o <= 1'b0;
    end else begin
      rd_valid_o  <= 1'b0;
      rd_last_o   <= 1'b0;
      trunc_err_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (take) begin
          hi_q        <= hi_i;
          off_q       <= off_i;
          left_q      <= len_i;
          page_q      <= page_en_i;
          trunc_err_o <= err_i;
          state_q     <= ST_ACCESS;
        end
        ST_ACCESS: if (tmr_done_i) begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= mem_rdata_i;
          rd_off_o   <= off_q;
          rd_last_o  <= last_word;
          if (last_word) begin
            state_q <= ST_IDLE;
          end else begin
            left_q <= left_q - 1'b1;
            off_q  <= off_q + 1'b1;
            if (!page_q) state_q <= ST_GAP;
          end
        end
        ST_GAP: if (tmr_done_i) state_q <= ST_ACCESS;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // chip-enable low-time watch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ce_low_q <= '0;
    else if (mem_ce_no)           ce_low_q <= '0;
    else if (ce_low_q != '1)      ce_low_q <= ce_low_q + 1'b1;
  end

  assign mem_addr_o = {hi_q, off_q};
  assign mem_ce_no  = state_q != ST_ACCESS;
  assign mem_oe_no  = state_q != ST_ACCESS;
  assign busy_o     = state_q != ST_IDLE;

  a_r4_hi_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));

  a_r5_addr_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_q && !mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));

  a_r9_ce_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mem_ce_no);

  a_r9_ce_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_low_q < CEC_W'(CE_MAX_CYC));

  a_r8_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  a_r6_err_on_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_err_o |-> $past(start_i && !busy_o));

  a_r3_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !page_q) |=> !rd_valid_o);

endmodule

// File: rtl/page_burst_rd.sv
module page_burst_rd
  import page_burst_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 22,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned OFF_W       = 4,
  parameter int unsigned T_FIRST_CYC = 7,
  parameter int unsigned T_PAGE_CYC  = 2,
  parameter int unsigned T_GAP_CYC   = 1,
  parameter int unsigned CE_MAX_CYC  = 1000,
  localparam int unsigned CNT_W = OFF_W + 1,
  localparam int unsigned HI_W  = ADDR_W - OFF_W,
  localparam int unsigned TMR_W = $clog2(max3(T_FIRST_CYC, T_PAGE_CYC, T_GAP_CYC) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic              page_en_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic              rd_last_o,
  output logic              busy_o,
  output logic              trunc_err_o
);
  logic [CNT_W-1:0] len;
  logic             err, zero;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;

  pbr_req_clip #(.OFF_W(OFF_W)) u_clip (
    .off_i  (start_addr_i[OFF_W-1:0]),
    .cnt_i  (word_cnt_i),
    .len_o  (len),
    .err_o  (err),
    .zero_o (zero)
  );

  pbr_wait_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  pbr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .T_FIRST_CYC(T_FIRST_CYC), .T_PAGE_CYC(T_PAGE_CYC), .T_GAP_CYC(T_GAP_CYC),
    .CE_MAX_CYC(CE_MAX_CYC), .TMR_W(TMR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .hi_i        (start_addr_i[ADDR_W-1:OFF_W]),
    .off_i       (start_addr_i[OFF_W-1:0]),
    .len_i       (len),
    .err_i       (err),
    .zero_i      (zero),
    .page_en_i   (page_en_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_no   (mem_ce_no),
    .mem_oe_no   (mem_oe_no),
    .mem_rdata_i (mem_rdata_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .rd_off_o    (rd_off_o),
    .rd_last_o   (rd_last_o),
    .busy_o      (busy_o),
    .trunc_err_o (trunc_err_o)
  );

  initial begin
    if (T_FIRST_CYC < 1 || T_PAGE_CYC < 1 || T_GAP_CYC < 1 || HI_W < 1)
      $error("page_burst_rd: bad timing or width parameter");
  end

endmodule

// File: tb/page_burst_rd_tb_top.sv
module page_burst_rd_tb_top;
  localparam int AW = 22, DW = 16, OW = 4, TF = 7, TP = 2, TG = 1, CEM = 1000;
  localparam int CW = OW + 1;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0, page_en_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] word_cnt_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ce_no, mem_oe_no;
  logic [DW-1:0] mem_rdata_i = 16'hDEAD;
  logic          rd_valid_o, rd_last_o, busy_o, trunc_err_o;
  logic [DW-1:0] rd_data_o;
  logic [OW-1:0] rd_off_o;

  page_burst_rd #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW), .T_FIRST_CYC(TF),
                  .T_PAGE_CYC(TP), .T_GAP_CYC(TG), .CE_MAX_CYC(CEM)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit run_on = 1'b0;
  int err_at = -1;
  bit cur_pe = 1'b0;

  int      q_cyc[$];
  logic [DW-1:0] q_dat[$];
  int      q_off[$];
  bit      q_last[$];
  string   q_tag[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {a[11:0], a[3:0]} ^ 16'h5A3C ^ {a[21:12], 6'd0};
  endfunction

  // memory model: data only after the proper access window
  logic [AW-1:0] prev_addr = '0;
  bit prev_low = 1'b0, need_full = 1'b1;
  int age = 0;
  always @(negedge clk_i) begin
    if (mem_ce_no) begin
      age = 0;
      prev_low = 1'b0;
    end else begin
      if (!prev_low || mem_addr_o != prev_addr) begin
        need_full = !prev_low || !cur_pe || (mem_addr_o[AW-1:OW] != prev_addr[AW-1:OW]);
        age = 1;
      end else age++;
      prev_low = 1'b1;
    end
    prev_addr = mem_addr_o;
    mem_rdata_i <= (!mem_ce_no && !mem_oe_no && age >= (need_full ? TF : TP))
                   ? pat(mem_addr_o) : 16'hDEAD;
  end

  // per-clock comparison against the expected stream
  always @(negedge clk_i) begin
    if (run_on) begin
      if (!busy_o) chk(mem_ce_no == 1'b1, "R9 ce high when idle", mem_ce_no, 1);
      chk(mem_oe_no == mem_ce_no, "R10 oe follows ce", mem_oe_no, mem_ce_no);
      if (trunc_err_o || cyc == err_at)
        chk(trunc_err_o == (cyc == err_at), "R6 truncation flag", trunc_err_o, cyc == err_at);
      if (rd_valid_o) begin
        if (q_cyc.size() == 0) chk(1'b0, "R2 unexpected word", rd_data_o, 0);
        else begin
          chk(cyc == q_cyc[0], {q_tag[0], " word timing"}, cyc, q_cyc[0]);
          chk(rd_data_o == q_dat[0], {q_tag[0], " word data"}, rd_data_o, q_dat[0]);
          chk(rd_off_o == q_off[0], "R8 offset tag", rd_off_o, q_off[0]);
          chk(rd_last_o == q_last[0], "R8 last marker", rd_last_o, q_last[0]);
          void'(q_cyc.pop_front()); void'(q_dat.pop_front()); void'(q_off.pop_front());
          void'(q_last.pop_front()); void'(q_tag.pop_front());
        end
      end else if (q_cyc.size() != 0 && cyc > q_cyc[0]) begin
        chk(1'b0, {q_tag[0], " missing word"}, 0, q_cyc[0]);
        void'(q_cyc.pop_front()); void'(q_dat.pop_front()); void'(q_off.pop_front());
        void'(q_last.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic issue(logic [AW-1:0] a, int cnt, bit pe);
    int off, room, len, e;
    while (busy_o) @(negedge clk_i);
    start_addr_i = a; word_cnt_i = CW'(cnt); page_en_i = pe; start_i = 1'b1;
    e = cyc + 1;
    off = int'(a[OW-1:0]); room = 16 - off;
    len = (cnt > room) ? room : cnt;
    if (cnt != 0) begin
      cur_pe = pe;
      if (cnt > room) err_at = e;
      for (int i = 0; i < len; i++) begin
        q_cyc.push_back(pe ? e + TF + i * TP : e + i * (TF + TG) + TF);
        q_dat.push_back(pat({a[AW-1:OW], OW'(off + i)}));
        q_off.push_back(off + i);
        q_last.push_back(i == len - 1);
        q_tag.push_back(i == 0 ? "R3" : (pe ? "R4" : "R5"));
      end
    end
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_burst();
    while (busy_o || q_cyc.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
    chk(mem_ce_no == 1'b1, "R9 ce high after burst", mem_ce_no, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_ce_no && mem_oe_no, "R1 reset enables", {mem_ce_no, mem_oe_no}, 3);
    chk(!busy_o && !rd_valid_o && !trunc_err_o, "R1 reset outputs",
        {busy_o, rd_valid_o, trunc_err_o}, 0);
    run_on = 1'b1;

    issue(22'h000120, 16, 1'b1); finish_burst();   // R4 full page
    issue(22'h3FFFF5, 3, 1'b1);  finish_burst();   // R4 top of space
    issue(22'h00004C, 10, 1'b1); finish_burst();   // R6 cut to 4
    issue(22'h012345, 4, 1'b0);  finish_burst();   // R5 random reads
    issue(22'h2ABCDF, 16, 1'b0); finish_burst();   // R6 cut to 1
    issue(22'h155550, 1, 1'b1);  finish_burst();   // R8 single word last

    // R7: zero count ignored
    issue(22'h000200, 0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      chk(!busy_o && mem_ce_no, "R7 zero count ignored", {busy_o, mem_ce_no}, 1);
      @(negedge clk_i);
    end

    // R2: start during busy has no effect
    issue(22'h0A0308, 8, 1'b1);
    repeat (4) @(negedge clk_i);
    start_addr_i = 22'h111110; word_cnt_i = 5'd3; page_en_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(mem_addr_o[AW-1:OW] == 18'h0A030, "R2 running burst kept",
        mem_addr_o[AW-1:OW], 18'h0A030);
    finish_burst();

    repeat (5) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule